// File: doc/BRIEF.md
# Power-down exit restore sequencer

This block brings a controller core back from hibernation. A one-cycle restore request, taken only while the block is idle, carries two flags: whether the core runs as host or as device, and whether the exit was caused by a remote wakeup. The request also carries the clock-gating control word that was saved before power-down. The block then steps through the rail controls in a fixed order, with a fixed wait after each step. It switches the core supply on, puts the core into reset, enables restore from the power controller, drops the isolation clamp, releases the core reset, and finally deselects the power-controller interrupt.

Next comes the essential-register step. Pending interrupt status is cleared and only the restore-done interrupt is unmasked. A control word derived from the saved value is then written twice: first with the mode-dependent restore bits, then with the restored flag added. After that the block polls a restore-done input for a bounded number of cycles. It finishes with a one-cycle done pulse. If the poll window expires, it also sets a sticky timeout flag. All waits are counted in clock cycles, using a parameter that gives the number of cycles per microsecond (written C below).

Top module: `pwrdn_restore_seq`

## Requirements
- R1: After reset the outputs hold their power-down values: pwr_off_o=1, core_rst_n_o=1, restore_en_o=0, clamp_o=1, pmu_sel_o=1, ctl_we_o=0, irq_clr_o=0, rdone_unmask_o=0, busy_o=0, done_o=0, timeout_o=0.
- R2: A request sampled at clock edge E sets pwr_off_o low at E. core_rst_n_o falls 10C edges later. restore_en_o rises 10C edges after that, and clamp_o falls another 10C edges later. In host mode, or in device mode without remote wakeup, core_rst_n_o rises 50C edges after the clamp falls. pmu_sel_o falls 10C edges after core_rst_n_o rises.
- R3: In device mode with remote wakeup, the gap from the clamp falling to core_rst_n_o rising is 120C edges (50C plus an extra 70C).
- R4: Bits 31:14 of every written control word equal the saved word, except bit 17. Bit 17 is forced to 1 when the saved speed field is 0 (bits 28:27 in host mode, bits 20:19 in device mode); otherwise it keeps its saved value. Bits 13:0 are zero apart from bits 9, 10 and 2.
- R5: In host mode, bit 9 of the control word is set exactly when remote wakeup is active, and bit 10 is never set.
- R6: In device mode, bits 9 and 10 are both set exactly when remote wakeup is not active.
- R7: The first control write (a one-cycle ctl_we_o) comes 10C edges after pmu_sel_o falls. In the same cycle irq_clr_o pulses and rdone_unmask_o rises, and bit 2 is 0. The second write comes 10C edges later and equals the first with bit 2 set. Exactly two writes and one clear happen per sequence.
- R8: Polling starts 10C edges after the second write. With rdone_i high at poll edge P+k (k≥1), done_o pulses at P+k, busy_o is low from then on, and timeout_o stays 0. A rdone_i pulse that ends before polling starts has no effect.
- R9: If rdone_i stays low for the whole poll window of TMO_CYCLES edges, done_o pulses at P+TMO_CYCLES and timeout_o is set. timeout_o then stays 1 until reset, even across later successful sequences. rdone_unmask_o is 0 after every done.
- R10: A request that arrives while busy_o is high is ignored. Its flags and saved word change neither the timing nor the control words of the sequence already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Restore request, one cycle |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode (taken with the request) |
| rwake_i | input | 1 | Remote-wakeup exit (taken with the request) |
| saved_ctl_i | input | 32 | Saved clock-gating control word (taken with the request) |
| rdone_i | input | 1 | Restore-done status from the core |
| pwr_off_o | output | 1 | Core supply switch off |
| core_rst_n_o | output | 1 | Core reset, active low |
| restore_en_o | output | 1 | Restore from the power controller enabled |
| clamp_o | output | 1 | Isolation clamp active |
| pmu_sel_o | output | 1 | Power-controller interrupt selected |
| ctl_word_o | output | 32 | Control word to write |
| ctl_we_o | output | 1 | Control word write strobe |
| irq_clr_o | output | 1 | Clear-all-pending-interrupts strobe |
| rdone_unmask_o | output | 1 | Only the restore-done interrupt is unmasked |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one cycle |
| timeout_o | output | 1 | Sticky poll timeout |

## Verification
The ordering properties assume that reset is asserted from time zero, and that requests and rdone_i are driven between clock edges. The bench drives rdone_i only after the second control write, except for one deliberate early pulse that ends before polling. Requests made while busy carry inverted flags and an inverted saved word, so any leak into the running sequence would show up in the measured edge gaps or in the written words. The bench measures each output transition as a clock-edge index, away from the active edge, and compares the gaps with the per-mode values in R2 and R3.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int CW_W         = 32;
    localparam int KEEP_LSB     = 14;
    localparam int HS_FORCE_BIT = 17;
    localparam int HOST_SPD_LSB = 27;
    localparam int DEV_SPD_LSB  = 19;
    localparam int RMODE_BIT    = 9;
    localparam int RSTPD_BIT    = 10;
    localparam int ESS_BIT      = 2;

    localparam logic [CW_W-1:0] KEEP_MASK = ~((CW_W'(1) << KEEP_LSB) - CW_W'(1));

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_RST,
        ST_REN,
        ST_CLMP,
        ST_URST,
        ST_PMU,
        ST_CW1,
        ST_CW2,
        ST_POLL
    } prs_state_e;

    typedef struct packed {
        logic host;
        logic rwake;
    } prs_mode_t;

    function automatic logic [CW_W-1:0] base_word(input logic [CW_W-1:0] saved,
                                                  input logic host);
        logic [CW_W-1:0] w;
        logic [1:0]      spd;
        w   = saved & KEEP_MASK;
        spd = host ? saved[HOST_SPD_LSB +: 2] : saved[DEV_SPD_LSB +: 2];
        if (spd == 2'b00)
            w[HS_FORCE_BIT] = 1'b1;
        return w;
    endfunction

    function automatic logic [CW_W-1:0] mode_bits(input prs_mode_t m);
        logic [CW_W-1:0] b;
        b = '0;
        if (m.host) begin
            if (m.rwake)
                b[RMODE_BIT] = 1'b1;
        end else if (!m.rwake) begin
            b[RMODE_BIT] = 1'b1;
            b[RSTPD_BIT] = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/prs_timer.sv
module prs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/prs_word.sv
module prs_word
    import prs_pkg::*;
(
    input  logic [CW_W-1:0] saved,
    input  prs_mode_t       mode,
    output logic [CW_W-1:0] word_first,
    output logic [CW_W-1:0] word_second
);
    always_comb begin
        word_first  = base_word(saved, mode.host) | mode_bits(mode);
        word_second = word_first;
        word_second[ESS_BIT] = 1'b1;
    end
endmodule

// File: rtl/pwrdn_restore_seq.sv
module pwrdn_restore_seq
    import prs_pkg::*;
#(
    parameter int CYC_PER_US = 50,
    parameter int TMO_CYCLES = 20000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            host_mode_i,
    input  logic            rwake_i,
    input  logic [CW_W-1:0] saved_ctl_i,
    input  logic            rdone_i,
    output logic            pwr_off_o,
    output logic            core_rst_n_o,
    output logic            restore_en_o,
    output logic            clamp_o,
    output logic            pmu_sel_o,
    output logic [CW_W-1:0] ctl_word_o,
    output logic            ctl_we_o,
    output logic            irq_clr_o,
    output logic            rdone_unmask_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            timeout_o
);
    localparam int STEP_CYC  = 10 * CYC_PER_US;
    localparam int CLMP_CYC  = 50 * CYC_PER_US;
    localparam int XTRA_CYC  = 70 * CYC_PER_US;
    localparam int LONG_CYC  = CLMP_CYC + XTRA_CYC;
    localparam int MAX_CYC   = (LONG_CYC > TMO_CYCLES) ? LONG_CYC : TMO_CYCLES;
    localparam int TW        = $clog2(MAX_CYC + 1);

    prs_state_e      state;
    prs_mode_t       mode_q;
    logic [CW_W-1:0] saved_q;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_zero;
    logic [CW_W-1:0] w_first;
    logic [CW_W-1:0] w_second;

    prs_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    prs_word u_word (
        .saved       (saved_q),
        .mode        (mode_q),
        .word_first  (w_first),
        .word_second (w_second)
    );

    // Timer reload: value for the wait that follows the step being taken.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TW'(STEP_CYC - 1);
        unique case (state)
            ST_IDLE: tmr_load = req_i;
            ST_REN: begin
                tmr_load = tmr_zero;
                tmr_val  = (!mode_q.host && mode_q.rwake) ? TW'(LONG_CYC - 1)
                                                          : TW'(CLMP_CYC - 1);
            end
            ST_CW2: begin
                tmr_load = tmr_zero;
                tmr_val  = TW'(TMO_CYCLES - 1);
            end
            ST_POLL: tmr_load = 1'b0;
            default: tmr_load = tmr_zero;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            mode_q         <= '0;
            saved_q        <= '0;
            pwr_off_o      <= 1'b1;
            core_rst_n_o   <= 1'b1;
            restore_en_o   <= 1'b0;
            clamp_o        <= 1'b1;
            pmu_sel_o      <= 1'b1;
            ctl_word_o     <= '0;
            ctl_we_o       <= 1'b0;
            irq_clr_o      <= 1'b0;
            rdone_unmask_o <= 1'b0;
            done_o         <= 1'b0;
            timeout_o      <= 1'b0;
        end else begin
            ctl_we_o  <= 1'b0;
            irq_clr_o <= 1'b0;
            done_o    <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_i) begin
                    mode_q    <= '{host: host_mode_i, rwake: rwake_i};
                    saved_q   <= saved_ctl_i;
                    pwr_off_o <= 1'b0;
                    state     <= ST_PWR;
                end
                ST_PWR: if (tmr_zero) begin
                    core_rst_n_o <= 1'b0;
                    state        <= ST_RST;
                end
                ST_RST: if (tmr_zero) begin
                    restore_en_o <= 1'b1;
                    state        <= ST_REN;
                end
                ST_REN: if (tmr_zero) begin
                    clamp_o <= 1'b0;
                    state   <= ST_CLMP;
                end
                ST_CLMP: if (tmr_zero) begin
                    core_rst_n_o <= 1'b1;
                    state        <= ST_URST;
                end
                ST_URST: if (tmr_zero) begin
                    pmu_sel_o <= 1'b0;
                    state     <= ST_PMU;
                end
                ST_PMU: if (tmr_zero) begin
                    ctl_word_o     <= w_first;
                    ctl_we_o       <= 1'b1;
                    irq_clr_o      <= 1'b1;
                    rdone_unmask_o <= 1'b1;
                    state          <= ST_CW1;
                end
                ST_CW1: if (tmr_zero) begin
                    ctl_word_o <= w_second;
                    ctl_we_o   <= 1'b1;
                    state      <= ST_CW2;
                end
                ST_CW2: if (tmr_zero) begin
                    state <= ST_POLL;
                end
                ST_POLL: begin
                    if (rdone_i) begin
                        done_o         <= 1'b1;
                        rdone_unmask_o <= 1'b0;
                        state          <= ST_IDLE;
                    end else if (tmr_zero) begin
                        done_o         <= 1'b1;
                        timeout_o      <= 1'b1;
                        rdone_unmask_o <= 1'b0;
                        state          <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/prs_chk.sv
module prs_chk
    import prs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pwr_off_o,
    input logic            core_rst_n_o,
    input logic            restore_en_o,
    input logic            clamp_o,
    input logic            pmu_sel_o,
    input logic [CW_W-1:0] ctl_word_o,
    input logic            ctl_we_o,
    input logic            irq_clr_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            timeout_o
);
    localparam logic [13:0] LOW_OK = 14'((1 << RMODE_BIT) | (1 << RSTPD_BIT) | (1 << ESS_BIT));

    // R2
    rst_release_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_n_o) |-> (!clamp_o && restore_en_o && !pwr_off_o));

    // R2
    pmu_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pmu_sel_o) |-> (core_rst_n_o && !clamp_o));

    // R7
    write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we_o |=> !ctl_we_o);

    // R7
    clear_with_first_write_chk: assert property (@(posedge clk) disable iff (rst)
        irq_clr_o |-> (ctl_we_o && !ctl_word_o[ESS_BIT] && !pmu_sel_o));

    // R4
    low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we_o |-> ((ctl_word_o[13:0] & ~LOW_OK) == 14'd0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R9
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> timeout_o);

    // R10
    busy_powered_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !pwr_off_o);
endmodule

bind pwrdn_restore_seq prs_chk u_prs_chk (.*);

// File: tb/tb_pwrdn_restore_seq.sv
module tb_pwrdn_restore_seq;
    localparam int C   = 2;
    localparam int TMO = 100;
    localparam int D10 = 10 * C;
    localparam int D50 = 50 * C;
    localparam int D120 = 120 * C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic        host_mode_i = 1'b0;
    logic        rwake_i = 1'b0;
    logic [31:0] saved_ctl_i = '0;
    logic        rdone_i = 1'b0;
    logic        pwr_off_o, core_rst_n_o, restore_en_o, clamp_o, pmu_sel_o;
    logic [31:0] ctl_word_o;
    logic        ctl_we_o, irq_clr_o, rdone_unmask_o, busy_o, done_o, timeout_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    pwrdn_restore_seq #(.CYC_PER_US(C), .TMO_CYCLES(TMO)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .host_mode_i(host_mode_i),
        .rwake_i(rwake_i), .saved_ctl_i(saved_ctl_i), .rdone_i(rdone_i),
        .pwr_off_o(pwr_off_o), .core_rst_n_o(core_rst_n_o),
        .restore_en_o(restore_en_o), .clamp_o(clamp_o), .pmu_sel_o(pmu_sel_o),
        .ctl_word_o(ctl_word_o), .ctl_we_o(ctl_we_o), .irq_clr_o(irq_clr_o),
        .rdone_unmask_o(rdone_unmask_o), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // recorded edge indices and words of the last run
    int t0, t_pwr, t_rf, t_ren, t_clmp, t_rr, t_pmu, t_w1, t_w2, t_done;
    int n_we, n_clr;
    logic [31:0] w1, w2;
    bit clr_ok, unmask_ok, to_at_done, busy_at_done, unmask_after;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_i = 1'b0; rdone_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input bit host, input bit rwake,
                                             input logic [31:0] s);
        logic [31:0] w;
        logic [1:0] spd;
        w = s & 32'hFFFF_C000;
        spd = host ? s[28:27] : s[20:19];
        if (spd == 2'b00) w[17] = 1'b1;
        if (host && rwake) w[9] = 1'b1;
        if (!host && !rwake) begin w[9] = 1'b1; w[10] = 1'b1; end
        return w;
    endfunction

    // rd_delay < 0: no rdone; early: pulse rdone between the writes; busy_at: offset of a stray request
    task automatic run_seq(input bit host, input bit rwake, input logic [31:0] s,
                           input int rd_delay, input bit early, input int busy_at,
                           input int busy_at2);
        bit p_pwr, p_rn, p_ren, p_clmp, p_pmu;
        bit got_done;
        t_pwr = -1; t_rf = -1; t_ren = -1; t_clmp = -1; t_rr = -1; t_pmu = -1;
        t_w1 = -1; t_w2 = -1; t_done = -1; n_we = 0; n_clr = 0;
        w1 = '0; w2 = '0; clr_ok = 0; unmask_ok = 0; got_done = 0;
        @(negedge clk);
        p_pwr = pwr_off_o; p_rn = core_rst_n_o; p_ren = restore_en_o;
        p_clmp = clamp_o; p_pmu = pmu_sel_o;
        host_mode_i = host; rwake_i = rwake; saved_ctl_i = s; req_i = 1'b1;
        t0 = cyc + 1;
        for (int i = 0; i < 5000 && !got_done; i++) begin
            @(negedge clk);
            req_i = 1'b0;
            if (busy_at >= 0 && cyc == t0 + busy_at || busy_at2 >= 0 && cyc == t0 + busy_at2) begin
                req_i = 1'b1; host_mode_i = !host; rwake_i = !rwake; saved_ctl_i = ~s;
            end
            if (p_pwr && !pwr_off_o) t_pwr = cyc;
            if (p_rn && !core_rst_n_o) t_rf = cyc;
            if (!p_rn && core_rst_n_o) t_rr = cyc;
            if (!p_ren && restore_en_o) t_ren = cyc;
            if (p_clmp && !clamp_o) t_clmp = cyc;
            if (p_pmu && !pmu_sel_o) t_pmu = cyc;
            p_pwr = pwr_off_o; p_rn = core_rst_n_o; p_ren = restore_en_o;
            p_clmp = clamp_o; p_pmu = pmu_sel_o;
            if (irq_clr_o) n_clr++;
            if (ctl_we_o) begin
                n_we++;
                if (n_we == 1) begin
                    t_w1 = cyc; w1 = ctl_word_o; clr_ok = irq_clr_o; unmask_ok = rdone_unmask_o;
                end else if (n_we == 2) begin
                    t_w2 = cyc; w2 = ctl_word_o;
                end
            end
            if (early && n_we == 1 && cyc == t_w1 + 2) rdone_i = 1'b1;
            if (early && n_we == 1 && cyc == t_w1 + 3) rdone_i = 1'b0;
            if (rd_delay >= 0 && n_we == 2 && cyc == t_w2 + D10 + rd_delay) rdone_i = 1'b1;
            if (done_o) begin
                got_done = 1; t_done = cyc; to_at_done = timeout_o; busy_at_done = busy_o;
                rdone_i = 1'b0;
            end
        end
        req_i = 1'b0;
        @(negedge clk);
        unmask_after = rdone_unmask_o;
    endtask

    task automatic check_run(input bit host, input bit rwake, input logic [31:0] s,
                             input int rd_delay, input bit exp_to, input bit first);
        int gap;
        logic [31:0] ew;
        gap = (!host && rwake) ? D120 : D50;
        ew = exp_word(host, rwake, s);
        if (first) begin
            check(t_pwr == t0, "R2 power on edge", t_pwr, t0);
            check(t_rf == t0 + D10, "R2 reset assert gap", t_rf - t0, D10);
            check(t_ren == t_rf + D10, "R2 restore enable gap", t_ren - t_rf, D10);
            check(t_clmp == t_ren + D10, "R2 clamp release gap", t_clmp - t_ren, D10);
            if (!host && rwake)
                check(t_rr == t_clmp + gap, "R3 extra wait before reset release", t_rr - t_clmp, gap);
            else
                check(t_rr == t_clmp + gap, "R2 reset release gap", t_rr - t_clmp, gap);
            check(t_pmu == t_rr + D10, "R2 pmu deselect gap", t_pmu - t_rr, D10);
            check(t_w1 == t_pmu + D10, "R7 first write gap", t_w1 - t_pmu, D10);
        end
        check(w1 == ew, host ? "R5 R4 first word host" : "R6 R4 first word device", w1, ew);
        check(w2 == (ew | 32'h4), "R7 second word", w2, ew | 32'h4);
        check(t_w2 == t_w1 + D10, "R7 second write gap", t_w2 - t_w1, D10);
        check(clr_ok && unmask_ok, "R7 clear and unmask with first write", {clr_ok, unmask_ok}, 2'b11);
        check(n_we == 2 && n_clr == 1, "R7 write and clear counts", n_we * 16 + n_clr, 33);
        if (exp_to)
            check(t_done == t_w2 + D10 + TMO, "R9 timeout done edge", t_done - t_w2, D10 + TMO);
        else
            check(t_done == t_w2 + D10 + rd_delay + 1, "R8 done edge", t_done - t_w2, D10 + rd_delay + 1);
        check(!busy_at_done, "R8 idle at done", busy_at_done, 0);
        check(!unmask_after, "R9 unmask cleared after done", unmask_after, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(pwr_off_o && core_rst_n_o && clamp_o && pmu_sel_o, "R1 rails high",
              {pwr_off_o, core_rst_n_o, clamp_o, pmu_sel_o}, 4'hF);
        check(!restore_en_o && !ctl_we_o && !irq_clr_o && !rdone_unmask_o, "R1 strobes low",
              {restore_en_o, ctl_we_o, irq_clr_o, rdone_unmask_o}, 0);
        check(!busy_o && !done_o && !timeout_o, "R1 status low", {busy_o, done_o, timeout_o}, 0);
    endtask

    task automatic t_host_rwake();
        do_reset();
        run_seq(1, 1, 32'h0800_3FFF, 3, 0, -1, -1);
        check_run(1, 1, 32'h0800_3FFF, 3, 0, 1);
        check(!to_at_done, "R8 no timeout", to_at_done, 0);
    endtask

    task automatic t_host_plain();
        do_reset();
        run_seq(1, 0, 32'h4000_C123, 0, 0, -1, -1);
        check_run(1, 0, 32'h4000_C123, 0, 0, 1);
    endtask

    task automatic t_dev_rwake();
        do_reset();
        run_seq(0, 1, 32'h0018_0000, 5, 0, -1, -1);
        check_run(0, 1, 32'h0018_0000, 5, 0, 1);
    endtask

    task automatic t_dev_plain();
        do_reset();
        run_seq(0, 0, 32'h1824_5678, 2, 0, -1, -1);
        check_run(0, 0, 32'h1824_5678, 2, 0, 1);
    endtask

    task automatic t_timeout_sticky();
        do_reset();
        run_seq(1, 0, 32'h0000_0000, -1, 1, -1, -1);
        check_run(1, 0, 32'h0000_0000, -1, 1, 1);
        check(to_at_done, "R8 early rdone ignored, R9 timeout set", to_at_done, 1);
        run_seq(0, 1, 32'hFFFF_FFFF, 1, 0, -1, -1);
        check_run(0, 1, 32'hFFFF_FFFF, 1, 0, 0);
        check(to_at_done && timeout_o, "R9 timeout sticky", timeout_o, 1);
    endtask

    task automatic t_busy_ignore();
        do_reset();
        run_seq(1, 0, 32'h0800_0000, 4, 0, 5, 4 * D10 + D50 + 2);
        check_run(1, 0, 32'h0800_0000, 4, 0, 1);
        check(!busy_o, "R10 no restart after stray requests", busy_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_host_rwake();
        t_host_plain();
        t_dev_rwake();
        t_dev_plain();
        t_timeout_sticky();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule